// File: doc/BRIEF.md
# DMA Protected Window Register Pair

This block holds the two bound registers that mark one region of host physical memory below 4 GB as off-limits to DMA. It also contains the address check that uses those bounds. Software programs a base and a limit through a small register port. A pulse input locks the pair against change and another pulse unlocks it. A capability input says whether the region feature exists at all, and a protection-enable input says whether the region is in force.

Each register keeps only its upper address bits. The low bits always read back as zero. When the limit is compared against an address, its low bits count as all ones, so the region always ends on the last byte of an aligned block. Software can find the alignment by writing all ones and looking for the highest bit that reads back as zero. The hit output is combinational. It rises when a DMA request address falls inside an enabled, well-formed region. A limit programmed below the base leaves the region empty.

Top module: `dma_prot_window`

## Requirements
- R1: After reset both registers read 0, the pair is unlocked, and `hit` is 0.
- R2: `reg_sel` = 0 selects the base and `reg_sel` = 1 selects the limit. Only bits 31:21 are stored. `rd_data` returns those bits with bits 20:0 at zero, so writing 0xFFFFFFFF reads back 0xFFE00000.
- R3: For the comparison, the limit's bits 20:0 act as all ones. With base 0 and limit 0x00200000, address 0x003FFFFF hits and 0x00400000 does not.
- R4: A `lock_pulse` makes every later write have no effect until an `unlock_pulse` arrives. After the unlock, writes take effect again.
- R5: While `cap_present` is 0, writes have no effect.
- R6: When base equals limit, the region is exactly 2 MiB starting at the base. With both at 0x40000000, addresses 0x40000000 and 0x401FFFFF hit, while 0x3FFFFFFF and 0x40200000 do not.
- R7: When the limit's stored bits are below the base's, no address hits.
- R8: Writes issued while `prot_en` is 1 have no effect.
- R9: `hit` is 0 whenever `prot_en` is 0.
- R10: When `lock_pulse` and `unlock_pulse` arrive in the same cycle, the pair becomes locked.
- R11: `rd_data` shows the stored bits whatever the lock and enable states are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 = base register, 1 = limit register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| lock_pulse | input | 1 | One-cycle command that locks the pair |
| unlock_pulse | input | 1 | One-cycle command that unlocks the pair |
| cap_present | input | 1 | 1 when the region feature is supported |
| prot_en | input | 1 | 1 while the region is in force |
| req_addr | input | 32 | DMA request address to check |
| hit | output | 1 | Address lies in the enabled region |

## Verification
The assertions check on every cycle that the stored bounds stay fixed while the pair is locked, the capability is absent, or protection is enabled. They also check that the read-back low bits stay zero, that a lock command always leaves the pair locked, and that no hit occurs while protection is off or the bounds are inverted. The bench scenarios are needed to show the exact region edges: the all-ones limit decode, the 2 MiB window when the bounds are equal, and the addresses one byte outside each edge. The scenarios also show that an unlock restores write access and that the read-back value of a write matches the alignment rule.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int PMR_ADDR_W = 32;
    localparam int PMR_LOW_W  = 21;
    localparam int PMR_HI_W   = PMR_ADDR_W - PMR_LOW_W;
    localparam int PMR_NREG   = 2;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } pmr_sel_e;

    typedef struct packed {
        logic [PMR_HI_W-1:0] base_hi;
        logic [PMR_HI_W-1:0] limit_hi;
    } pmr_bounds_t;

    function automatic logic [PMR_ADDR_W-1:0] pmr_floor(input logic [PMR_HI_W-1:0] hi);
        return {hi, {PMR_LOW_W{1'b0}}};
    endfunction

    function automatic logic [PMR_ADDR_W-1:0] pmr_ceil(input logic [PMR_HI_W-1:0] hi);
        return {hi, {PMR_LOW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/pmr_lock_ctrl.sv
module pmr_lock_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic lock_pulse,
    input  logic unlock_pulse,
    input  logic cap_present,
    input  logic prot_en,
    input  logic wr_en,
    output logic locked,
    output logic wr_ok
);

    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst)
            locked_q <= 1'b0;
        else if (lock_pulse)
            locked_q <= 1'b1;
        else if (unlock_pulse)
            locked_q <= 1'b0;
    end

    assign locked = locked_q;
    assign wr_ok  = wr_en && cap_present && !locked_q && !prot_en;

    // R10: a lock command always leaves the pair locked, even with unlock present
    a_r10_lock_wins: assert property (@(posedge clk) disable iff (rst)
        lock_pulse |=> locked_q);

    // R4: an unlock without a lock clears the locked state
    a_r4_unlock_clears: assert property (@(posedge clk) disable iff (rst)
        (unlock_pulse && !lock_pulse) |=> !locked_q);

endmodule

// File: rtl/pmr_bound_reg.sv
module pmr_bound_reg #(
    parameter int HI_W = pmr_pkg::PMR_HI_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [HI_W-1:0] d_hi,
    output logic [HI_W-1:0] q_hi
);

    always_ff @(posedge clk) begin
        if (rst)
            q_hi <= '0;
        else if (load)
            q_hi <= d_hi;
    end

endmodule

// File: rtl/pmr_region_match.sv
module pmr_region_match #(
    parameter int ADDR_W = pmr_pkg::PMR_ADDR_W,
    parameter int LOW_W  = pmr_pkg::PMR_LOW_W,
    localparam int HI_W  = ADDR_W - LOW_W
) (
    input  logic [HI_W-1:0]   base_hi,
    input  logic [HI_W-1:0]   limit_hi,
    input  logic              prot_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W-1:0] lo_bound;
    logic [ADDR_W-1:0] hi_bound;
    logic              well_formed;

    always_comb begin
        lo_bound    = {base_hi, {LOW_W{1'b0}}};
        hi_bound    = {limit_hi, {LOW_W{1'b1}}};
        well_formed = (limit_hi >= base_hi);
        hit         = prot_en && well_formed && (addr >= lo_bound) && (addr <= hi_bound);
    end

endmodule

// File: rtl/dma_prot_window.sv
module dma_prot_window #(
    parameter int ADDR_W = pmr_pkg::PMR_ADDR_W,
    parameter int LOW_W  = pmr_pkg::PMR_LOW_W,
    localparam int HI_W  = ADDR_W - LOW_W,
    localparam int NREG  = pmr_pkg::PMR_NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              lock_pulse,
    input  logic              unlock_pulse,
    input  logic              cap_present,
    input  logic              prot_en,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit
);
    import pmr_pkg::*;

    logic            locked;
    logic            wr_ok;
    logic [HI_W-1:0] hi_q [NREG];
    logic            unused_low;

    assign unused_low = ^wr_data[LOW_W-1:0];

    pmr_lock_ctrl u_lock (
        .clk          (clk),
        .rst          (rst),
        .lock_pulse   (lock_pulse),
        .unlock_pulse (unlock_pulse),
        .cap_present  (cap_present),
        .prot_en      (prot_en),
        .wr_en        (wr_en),
        .locked       (locked),
        .wr_ok        (wr_ok)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_bound
        pmr_bound_reg #(.HI_W(HI_W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (wr_ok && (reg_sel == 1'(g))),
            .d_hi (wr_data[ADDR_W-1:LOW_W]),
            .q_hi (hi_q[g])
        );
    end

    always_comb begin
        if (pmr_sel_e'(reg_sel) == SEL_LIMIT)
            rd_data = {hi_q[SEL_LIMIT], {LOW_W{1'b0}}};
        else
            rd_data = {hi_q[SEL_BASE], {LOW_W{1'b0}}};
    end

    pmr_region_match #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_match (
        .base_hi  (hi_q[SEL_BASE]),
        .limit_hi (hi_q[SEL_LIMIT]),
        .prot_en  (prot_en),
        .addr     (req_addr),
        .hit      (hit)
    );

    // R4: a locked pair keeps both bounds
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(hi_q[0]) && $stable(hi_q[1])));

    // R5: no capability, no change
    a_r5_nocap_hold: assert property (@(posedge clk) disable iff (rst)
        !cap_present |=> ($stable(hi_q[0]) && $stable(hi_q[1])));

    // R8: bounds frozen while protection is enabled
    a_r8_enabled_hold: assert property (@(posedge clk) disable iff (rst)
        prot_en |=> ($stable(hi_q[0]) && $stable(hi_q[1])));

    // R2: low read bits are always zero
    a_r2_low_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[LOW_W-1:0] == '0);

    // R9: no hit with protection off
    a_r9_off_nohit: assert property (@(posedge clk) disable iff (rst)
        !prot_en |-> !hit);

    // R7: inverted bounds never hit
    a_r7_inverted_nohit: assert property (@(posedge clk) disable iff (rst)
        (hi_q[1] < hi_q[0]) |-> !hit);

endmodule

// File: tb/dma_prot_window_tb.sv
module dma_prot_window_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lock_pulse = 1'b0;
    logic        unlock_pulse = 1'b0;
    logic        cap_present = 1'b1;
    logic        prot_en = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dma_prot_window u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .lock_pulse(lock_pulse), .unlock_pulse(unlock_pulse),
        .cap_present(cap_present), .prot_en(prot_en), .req_addr(req_addr), .hit(hit)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        check32(req, rd_data, exp);
    endtask

    task automatic hit_chk(input string req, input logic [31:0] a, input logic exp);
        req_addr = a;
        #1;
        check32(req, {31'b0, hit}, {31'b0, exp});
    endtask

    task automatic pulse(input logic lk, input logic ul);
        @(negedge clk);
        lock_pulse = lk; unlock_pulse = ul;
        @(negedge clk);
        lock_pulse = 1'b0; unlock_pulse = 1'b0;
    endtask

    task automatic t_reset;
        read_chk("R1 base", 1'b0, 32'h0);
        read_chk("R1 limit", 1'b1, 32'h0);
        hit_chk("R1 hit", 32'h0, 1'b0);
    endtask

    task automatic t_readback;
        write_reg(1'b1, 32'hFFFF_FFFF);
        read_chk("R2 limit all ones", 1'b1, 32'hFFE0_0000);
        write_reg(1'b0, 32'h1234_5678);
        read_chk("R2 base", 1'b0, 32'h1220_0000);
    endtask

    task automatic t_limit_decode;
        write_reg(1'b0, 32'h0);
        write_reg(1'b1, 32'h0020_0000);
        prot_en = 1'b1;
        hit_chk("R3 last byte", 32'h003F_FFFF, 1'b1);
        hit_chk("R3 past end", 32'h0040_0000, 1'b0);
        hit_chk("R9 enabled inside", 32'h0010_0000, 1'b1);
        prot_en = 1'b0;
        hit_chk("R9 disabled inside", 32'h0010_0000, 1'b0);
    endtask

    task automatic t_equal;
        write_reg(1'b0, 32'h4000_0000);
        write_reg(1'b1, 32'h4000_0000);
        prot_en = 1'b1;
        hit_chk("R6 below", 32'h3FFF_FFFF, 1'b0);
        hit_chk("R6 start", 32'h4000_0000, 1'b1);
        hit_chk("R6 end", 32'h401F_FFFF, 1'b1);
        hit_chk("R6 after", 32'h4020_0000, 1'b0);
        prot_en = 1'b0;
    endtask

    task automatic t_inverted;
        write_reg(1'b1, 32'h2000_0000);
        prot_en = 1'b1;
        hit_chk("R7 at base", 32'h4000_0000, 1'b0);
        hit_chk("R7 between", 32'h3000_0000, 1'b0);
        hit_chk("R7 at limit", 32'h2000_0000, 1'b0);
        prot_en = 1'b0;
    endtask

    task automatic t_enabled_write;
        prot_en = 1'b1;
        write_reg(1'b1, 32'h6000_0000);
        read_chk("R8 limit kept", 1'b1, 32'h2000_0000);
        read_chk("R11 read while enabled", 1'b0, 32'h4000_0000);
        prot_en = 1'b0;
    endtask

    task automatic t_lock;
        pulse(1'b1, 1'b0);
        write_reg(1'b1, 32'h7000_0000);
        read_chk("R4 locked write dropped", 1'b1, 32'h2000_0000);
        read_chk("R11 read while locked", 1'b0, 32'h4000_0000);
        pulse(1'b0, 1'b1);
        write_reg(1'b1, 32'h7000_0000);
        read_chk("R4 unlocked write", 1'b1, 32'h7000_0000);
    endtask

    task automatic t_both_pulses;
        pulse(1'b1, 1'b1);
        write_reg(1'b0, 32'h8000_0000);
        read_chk("R10 lock wins", 1'b0, 32'h4000_0000);
        pulse(1'b0, 1'b1);
    endtask

    task automatic t_nocap;
        cap_present = 1'b0;
        write_reg(1'b0, 32'hA000_0000);
        read_chk("R5 no capability", 1'b0, 32'h4000_0000);
        cap_present = 1'b1;
        write_reg(1'b0, 32'hA000_0000);
        read_chk("R5 capability back", 1'b0, 32'hA000_0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset;
                t_readback;
                t_limit_decode;
                t_equal;
                t_inverted;
                t_enabled_write;
                t_lock;
                t_both_pulses;
                t_nocap;
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule